// File: doc/BRIEF.md
# Shared Pseudo-Random Noise Source

This block produces one pseudo-random noise level that every sound channel of a three-voice tone synthesizer reads. A clock-enable tick arrives once every eight system clocks. A prescaler halves that tick rate, which gives the step rate. A period counter then reduces the step rate by a programmable 5-bit period. Each time the counter fires, a 17-bit linear-feedback shift register moves one place right.

The audible level is not the register's low bit. It is a toggle flip-flop that flips on every update where the low bit, read before the shift, is 1. The generator runs all the time. It has no enable, and it keeps running whether or not any channel uses noise. Tone mixing, register access and the output converter belong to neighbouring blocks.

Top module: `noise_lfsr_gen`

## Requirements
- R1: After synchronous reset the noise level is 0, the shift register holds the seed value 1, and the prescaler and period counter are at 0. The first update therefore drives the level to 1.
- R2: With a nonzero period P, the register advances once every P prescaled steps, which is one update for every 2·P input ticks.
- R3: A period value of 0 gives exactly the same update timing as a period value of 1.
- R4: On each update the register shifts right by one position. The bit entering position 16 is the XOR of bits 0 and 3 taken before the shift. The register never becomes all zeros.
- R5: On each update the noise level is XORed with the pre-shift bit 0. The level flips when that bit is 1 and holds when it is 0.
- R6: The period counter counts up from 0 and fires when count+1 reaches or exceeds the effective period, then restarts at 0. If the period is lowered below the current count, the counter fires on the next step.
- R7: Without an input tick, the noise level and all internal state hold their values.
- R8: Only every second input tick produces a step, so two consecutive steps are never generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock-enable tick, one system clock in eight |
| period_i | input | 5 | Noise period; 0 is treated as 1 |
| noise_o | output | 1 | Registered shared noise level |

## Verification
The bench alternates the period between very short values, 0, and the maximum while ticks arrive at irregular times. This exposes a design that counts down or compares only for equality: when the period is shortened mid-count, such a design would skip an update or wait for the counter to wrap. Period 0 is run directly against period 1, so a design that treats 0 as a stall or as 32 shows the wrong rate. Long runs of updates compare the level against an independent model. A level that copied bit 0, or a misplaced tap, would differ within a few updates, and a prescaler that dropped the halving would double the rate.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int unsigned NOISE_PER_W  = 5;
  localparam int unsigned NOISE_LFSR_W = 17;
  localparam int unsigned NOISE_TAP    = 3;
  localparam int unsigned NOISE_SEED   = 1;
  localparam int unsigned NOISE_PREDIV = 2;
endpackage

// File: rtl/noise_prescale.sv
module noise_prescale #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic step_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pc;

  assign step_o = tick_i && (pc == LAST);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else if (tick_i) pc <= (pc == LAST) ? '0 : pc + 1'b1;
  end

  AST_NO_BACK_TO_BACK_STEP: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o); // R8
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(pc)); // R7
endmodule

// File: rtl/noise_period_ctr.sv
module noise_period_ctr #(
  parameter int unsigned PER_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [PER_W-1:0] period_i,
  output logic             fire_o
);
  localparam int unsigned XW = PER_W + 1;

  logic [PER_W-1:0] cnt;
  logic [XW-1:0]    eff;
  logic [XW-1:0]    nxt;

  always_comb begin
    eff = (period_i == '0) ? XW'(1) : {1'b0, period_i};
    nxt = {1'b0, cnt} + XW'(1);
  end

  assign fire_o = step_i && (nxt >= eff);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (step_i) cnt <= (nxt >= eff) ? '0 : nxt[PER_W-1:0];
  end

  AST_FIRE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> (cnt == '0)); // R6
  AST_FIRE_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> step_i); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cnt)); // R7
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int unsigned W    = 17,
  parameter int unsigned TAP  = 3,
  parameter int unsigned SEED = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_i,
  output logic level_o
);
  logic [W-1:0] sr;
  logic         fb;

  assign fb = sr[0] ^ sr[TAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= W'(SEED);
      level_o <= 1'b0;
    end else if (upd_i) begin
      sr      <= {fb, sr[W-1:1]};
      level_o <= level_o ^ sr[0];
    end
  end

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    sr != '0); // R4
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> (sr[W-2:0] == $past(sr[W-1:1]))); // R4
  AST_LEVEL_KEEP_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !sr[0]) |=> $stable(level_o)); // R5
  AST_LEVEL_FLIP_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    (upd_i && sr[0]) |=> (level_o != $past(level_o))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(level_o) && $stable(sr)); // R7
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_pkg::*;
#(
  parameter int unsigned PER_W  = NOISE_PER_W,
  parameter int unsigned LFSR_W = NOISE_LFSR_W,
  parameter int unsigned TAP    = NOISE_TAP,
  parameter int unsigned SEED   = NOISE_SEED,
  parameter int unsigned PREDIV = NOISE_PREDIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             noise_o
);
  logic step;
  logic fire;

  noise_prescale #(.DIV(PREDIV)) u_pre (
    .clk(clk), .rst(rst), .tick_i(tick_i), .step_o(step)
  );

  noise_period_ctr #(.PER_W(PER_W)) u_ctr (
    .clk(clk), .rst(rst), .step_i(step), .period_i(period_i), .fire_o(fire)
  );

  noise_lfsr #(.W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .upd_i(fire), .level_o(noise_o)
  );

  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(noise_o)); // R7
endmodule

// File: tb/test_noise_lfsr_gen.sv
module test_noise_lfsr_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic [4:0] period_i = 5'd1;
  logic       noise_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  noise_lfsr_gen i_noise_lfsr_gen (
    .clk(clk), .rst(rst), .tick_i(tick_i), .period_i(period_i), .noise_o(noise_o)
  );

  // independent reference model built from the requirements
  logic [16:0] m_sr;
  logic        m_lvl;
  int          m_pc, m_cnt, m_upds;

  function automatic int eff_per(input logic [4:0] p);
    return (p == 0) ? 1 : int'(p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sr <= 17'd1; m_lvl <= 1'b0; m_pc <= 0; m_cnt <= 0; m_upds <= 0;
    end else if (tick_i) begin
      if (m_pc == 1) begin
        m_pc <= 0;
        if (m_cnt + 1 >= eff_per(period_i)) begin
          m_cnt  <= 0;
          m_upds <= m_upds + 1;
          m_lvl  <= m_lvl ^ m_sr[0];
          m_sr   <= {m_sr[0] ^ m_sr[3], m_sr[16:1]};
        end else m_cnt <= m_cnt + 1;
      end else m_pc <= 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: noise_o actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic t, input logic [4:0] p);
    @(negedge clk);
    begin
      string r;
      if (period_i == 0) r = "R3";
      else if (!tick_i) r = "R7";
      else r = "R4 R5 R6";
      check(r, noise_o, m_lvl);
    end
    tick_i = t; period_i = p;
  endtask

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", noise_o, 1'b0);
    // R1/R8: ticks held high, period 1: first tick no step, second updates
    tick_i = 1'b1; period_i = 5'd1;
    @(negedge clk); check("R8", noise_o, 1'b0);
    @(negedge clk); check("R1", noise_o, 1'b1);
    tick_i = 1'b0;
    // R2: period 3, count updates over 60 ticks -> 10
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 60; i++) cyc(1'b1, 5'd3);
    cyc(1'b0, 5'd3);
    n_run++;
    if (m_upds != 10) begin
      n_fail++; $display("FAIL R2: model updates actual=%0d expected=10", m_upds);
    end
    // R3: period 0 run, then period 1 run
    for (int i = 0; i < 400; i++) cyc(1'b1, 5'd0);
    for (int i = 0; i < 400; i++) cyc(1'b1, 5'd1);
    // R6: long period then shortened mid-count
    for (int i = 0; i < 50; i++) cyc(1'b1, 5'd31);
    for (int i = 0; i < 20; i++) cyc(1'b1, 5'd2);
    // R7: no ticks with period changes
    for (int i = 0; i < 40; i++) cyc(1'b0, 5'($urandom_range(0, 31)));
    // random mix
    for (int i = 0; i < 30000; i++) begin
      logic [4:0] p;
      p = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31)) : period_i;
      if ($urandom_range(0, 15) == 0) p = 5'($urandom_range(0, 3));
      cyc(($urandom_range(0, 2) != 0), p);
    end
    // R7 via continuous tick at max period then idle
    for (int i = 0; i < 2000; i++) cyc(1'b1, 5'd31);
    cyc(1'b0, 5'd31);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule